// File: doc/BRIEF.md
# HALT Wake-Up Sequencer

This block controls the low-power halt state of a small microcontroller core. When the core asks to halt, the sequencer drops the system clock enable and holds the core. While halted it watches four kinds of wake source: an external reset request, interrupt request flags, falling edges on port-A pins that are enabled for wake-up, and a watchdog overflow. When one of these fires, the sequencer raises the clock enable again and keeps the core held for a fixed settling period of `SETTLE_CYC` system clocks. At the end of that period it sends a single-cycle exit strobe with a 2-bit action code. The code tells the core to resume at the next instruction, take the interrupt vector, perform a warm reset (program counter and stack pointer cleared) or perform a full reset.

An interrupt flag that was already set when the core entered halt cannot wake it. A new interrupt leads to vectoring only if that interrupt is enabled and the stack still has room. In every other case the core resumes at the next instruction. The sequencer itself runs on a free-running clock. The port-A edge detector runs from this clock, which in a real chip is the always-on tick domain, so edges are still seen while the core clock is gated.

Top module: `halt_wake_seq`

## Requirements
- R1: After reset `clk_en` is 1, `core_hold` is 0 and `exit_valid` is 0.
- R2: A `halt_req` sampled while running makes `clk_en` 0 and `core_hold` 1 from the next cycle on. Both stay that way until a wake event occurs.
- R3: The wake event is sampled at a clock edge. At that edge `clk_en` returns to 1, and `core_hold` stays 1 for exactly `SETTLE_CYC` cycles. The exit strobe is then visible after edge `SETTLE_CYC` following the wake edge, and `core_hold` is 0 from that point on.
- R4: `exit_valid` is high for exactly one cycle per wake. `exit_code` carries the action with the strobe: 0 = resume next instruction, 1 = take interrupt vector, 2 = warm reset, 3 = full reset.
- R5: A falling edge on a port-A pin whose `pa_wake_en` bit is 1 wakes the core with code 0. The edge passes two synchronizer flops and an edge register, so the wake edge is the third clock edge after the pin falls. Falling edges on disabled pins and rising edges cause no wake.
- R6: An interrupt flag bit that was 1 at the clock edge where halt was entered never wakes the core during that halt.
- R7: A newly set interrupt flag wakes the core. The code is 1 if at least one newly set flag has its `irq_en` bit at 1 and `stack_full` is 0 at the wake edge. Otherwise the code is 0.
- R8: A watchdog overflow while halted gives code 2. It takes priority over interrupt and port-A wake sources in the same cycle.
- R9: An external reset request while halted gives code 3. It takes priority over every other source in the same cycle.
- R10: Wake sources have no effect while running or settling. They produce no strobe and do not change the code or the timing of a settle already in progress.
- R11: `halt_req` is ignored while halted or settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Core requests entry into halt |
| ext_rst_req | input | 1 | External reset request (wake source, full reset) |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| irq_flags | input | N_IRQ | Interrupt request flags (level) |
| irq_en | input | N_IRQ | Per-interrupt enable bits |
| stack_full | input | 1 | Core stack has no free entry |
| pa_in | input | PA_W | Port-A pin levels (asynchronous) |
| pa_wake_en | input | PA_W | Per-pin wake-up enable options |
| clk_en | output | 1 | System clock enable for the core |
| core_hold | output | 1 | Hold the core (halted or settling) |
| exit_valid | output | 1 | One-cycle strobe at end of settling |
| exit_code | output | 2 | Exit action, valid with `exit_valid` |

## Verification
The bench goes after interrupt flags that are already pending at halt entry. A design that does not mask them would wake at once, and this shows up as a strobe during the quiet window. It checks the exact length of the settling delay for both the direct sources and the synchronized port-A path, so an off-by-one counter or a missing synchronizer stage shifts the strobe cycle. It mixes sources in the same cycle and varies the enable and stack-full inputs. A design with the wrong priority or vector condition then reports the wrong code. It also sends halt requests and watchdog pulses while the core is running or settling. A design that does not ignore them would produce a stray strobe or restart its delay.

// File: rtl/hws_pkg.sv
package hws_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_SETTLE = 2'd2
  } hws_state_e;

  typedef enum logic [1:0] {
    EXIT_RESUME = 2'd0,
    EXIT_VECTOR = 2'd1,
    EXIT_WARM   = 2'd2,
    EXIT_FULL   = 2'd3
  } hws_exit_e;
endpackage

// File: rtl/hws_pa_edge.sv
// Port-A falling-edge detector: two-flop synchronizer plus edge register per pin.
module hws_pa_edge #(
  parameter int PA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PA_W-1:0] pin_i,
  output logic [PA_W-1:0] fall_o
);
  logic [PA_W-1:0] meta_q, sync_q, prev_q;

  for (genvar b = 0; b < PA_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[b] <= 1'b1;
        sync_q[b] <= 1'b1;
        prev_q[b] <= 1'b1;
      end else begin
        meta_q[b] <= pin_i[b];
        sync_q[b] <= meta_q[b];
        prev_q[b] <= sync_q[b];
      end
    end
    assign fall_o[b] = prev_q[b] & ~sync_q[b];
  end
endmodule

// File: rtl/hws_wake_arb.sv
// Picks the wake source with the highest rank and forms the exit action.
module hws_wake_arb
  import hws_pkg::*;
#(
  parameter int N_IRQ = 4,
  parameter int PA_W  = 8
) (
  input  logic             ext_rst_i,
  input  logic             wdt_ovf_i,
  input  logic [N_IRQ-1:0] irq_new_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             stack_full_i,
  input  logic [PA_W-1:0]  pa_fall_i,
  input  logic [PA_W-1:0]  pa_en_i,
  output logic             wake_o,
  output hws_exit_e        code_o
);
  logic irq_any, irq_vec, pa_any;

  always_comb begin
    irq_any = |irq_new_i;
    irq_vec = (|(irq_new_i & irq_en_i)) & ~stack_full_i;
    pa_any  = |(pa_fall_i & pa_en_i);
    wake_o  = ext_rst_i | wdt_ovf_i | irq_any | pa_any;
    if (ext_rst_i)      code_o = EXIT_FULL;
    else if (wdt_ovf_i) code_o = EXIT_WARM;
    else if (irq_vec)   code_o = EXIT_VECTOR;
    else                code_o = EXIT_RESUME;
  end
endmodule

// File: rtl/hws_settle_cnt.sv
// Counts the settling period; done_o marks its last cycle.
module hws_settle_cnt #(
  parameter int SETTLE_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic done_o
);
  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == LAST) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = run_q && (cnt_q == LAST);

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !run_q);  // R3
endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq
  import hws_pkg::*;
#(
  parameter int N_IRQ      = 4,
  parameter int PA_W       = 8,
  parameter int SETTLE_CYC = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_req,
  input  logic             ext_rst_req,
  input  logic             wdt_ovf,
  input  logic [N_IRQ-1:0] irq_flags,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             stack_full,
  input  logic [PA_W-1:0]  pa_in,
  input  logic [PA_W-1:0]  pa_wake_en,
  output logic             clk_en,
  output logic             core_hold,
  output logic             exit_valid,
  output logic [1:0]       exit_code
);
  hws_state_e      state_q;
  logic [N_IRQ-1:0] mask_q;
  hws_exit_e       code_q;
  logic [PA_W-1:0] pa_fall;
  logic            wake;
  hws_exit_e       wake_code;
  logic            settle_done;
  logic            halting, waking;

  hws_pa_edge #(.PA_W(PA_W)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pa_in),
    .fall_o (pa_fall)
  );

  hws_wake_arb #(.N_IRQ(N_IRQ), .PA_W(PA_W)) u_arb (
    .ext_rst_i    (ext_rst_req),
    .wdt_ovf_i    (wdt_ovf),
    .irq_new_i    (irq_flags & ~mask_q),
    .irq_en_i     (irq_en),
    .stack_full_i (stack_full),
    .pa_fall_i    (pa_fall),
    .pa_en_i      (pa_wake_en),
    .wake_o       (wake),
    .code_o       (wake_code)
  );

  assign halting = (state_q == ST_RUN) && halt_req;
  assign waking  = (state_q == ST_HALT) && wake;

  hws_settle_cnt #(.SETTLE_CYC(SETTLE_CYC)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .start_i (waking),
    .done_o  (settle_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      mask_q     <= '0;
      code_q     <= EXIT_RESUME;
      clk_en     <= 1'b1;
      core_hold  <= 1'b0;
      exit_valid <= 1'b0;
      exit_code  <= 2'd0;
    end else begin
      exit_valid <= 1'b0;
      exit_code  <= 2'd0;
      unique case (state_q)
        ST_RUN: if (halting) begin
          state_q   <= ST_HALT;
          mask_q    <= irq_flags;
          clk_en    <= 1'b0;
          core_hold <= 1'b1;
        end
        ST_HALT: if (waking) begin
          state_q <= ST_SETTLE;
          code_q  <= wake_code;
          clk_en  <= 1'b1;
        end
        ST_SETTLE: if (settle_done) begin
          state_q    <= ST_RUN;
          core_hold  <= 1'b0;
          exit_valid <= 1'b1;
          exit_code  <= code_q;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  AST_HALT_GATES: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && halt_req) |=> (!clk_en && core_hold));  // R2
  AST_HOLD_WHEN_GATED: assert property (@(posedge clk) disable iff (rst)
    !clk_en |-> core_hold);  // R2
  AST_EXIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    exit_valid |=> !exit_valid);  // R4
  AST_EXIT_RELEASES: assert property (@(posedge clk) disable iff (rst)
    exit_valid |-> (clk_en && !core_hold));  // R3
  AST_FULL_FIRST: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT && ext_rst_req) |=> (state_q == ST_SETTLE && code_q == EXIT_FULL));  // R9
  AST_WARM_CODE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT && wdt_ovf && !ext_rst_req) |=> (code_q == EXIT_WARM));  // R8
endmodule

// File: tb/halt_wake_seq_tb_top.sv
`timescale 1ns/1ps
module halt_wake_seq_tb_top;
  localparam int N_IRQ = 4;
  localparam int PA_W  = 8;
  localparam int SETTLE_CYC = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_req = 0, ext_rst_req = 0, wdt_ovf = 0, stack_full = 0;
  logic [N_IRQ-1:0] irq_flags = '0, irq_en = '0;
  logic [PA_W-1:0]  pa_in = '1, pa_wake_en = '0;
  logic clk_en, core_hold, exit_valid;
  logic [1:0] exit_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  halt_wake_seq #(.N_IRQ(N_IRQ), .PA_W(PA_W), .SETTLE_CYC(SETTLE_CYC)) dut_i (
    .clk(clk), .rst(rst), .halt_req(halt_req), .ext_rst_req(ext_rst_req),
    .wdt_ovf(wdt_ovf), .irq_flags(irq_flags), .irq_en(irq_en),
    .stack_full(stack_full), .pa_in(pa_in), .pa_wake_en(pa_wake_en),
    .clk_en(clk_en), .core_hold(core_hold), .exit_valid(exit_valid),
    .exit_code(exit_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_code(input bit ext, input bit wdt,
                                  input logic [N_IRQ-1:0] newirq,
                                  input logic [N_IRQ-1:0] en, input bit sf);
    if (ext) return 3;
    if (wdt) return 2;
    if (newirq != 0 && (newirq & en) != 0 && !sf) return 1;
    return 0;
  endfunction

  task automatic enter_halt();
    @(negedge clk); halt_req = 1;
    @(negedge clk); halt_req = 0;
    check(clk_en == 0 && core_hold == 1, "R2 halt entry", {clk_en, core_hold}, 1);
  endtask

  // Waits for the strobe; returns negedges counted since stimulus.
  task automatic wait_exit(input int mid_chk, output int n, output int code);
    n = 0; code = -1;
    while (n < SETTLE_CYC + 20) begin
      @(negedge clk); n++;
      ext_rst_req = 0; wdt_ovf = 0;
      if (n == mid_chk)
        check(clk_en == 1 && core_hold == 1, "R3 settling clk_en/hold", {clk_en, core_hold}, 3);
      if (exit_valid) begin code = exit_code; break; end
    end
    @(negedge clk);
    check(exit_valid == 0 && core_hold == 0, "R4 strobe one cycle", exit_valid, 0);
  endtask

  task automatic quiet(input int cyc, input string req);
    bit seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (exit_valid || clk_en) seen = 1;
    end
    check(!seen && core_hold, req, seen, 0);
  endtask

  task automatic restore();
    @(negedge clk);
    irq_flags = '0; pa_in = '1; ext_rst_req = 0; wdt_ovf = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, code, kind, b, expn, expc;
    logic [N_IRQ-1:0] pre, newb;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(clk_en == 1 && core_hold == 0 && exit_valid == 0, "R1 reset state", {clk_en, core_hold, exit_valid}, 4);
    rst = 0;
    repeat (2) @(negedge clk);
    check(clk_en == 1 && core_hold == 0 && exit_valid == 0, "R1 after release", {clk_en, core_hold, exit_valid}, 4);

    // R10: wake sources while running do nothing
    wdt_ovf = 1; irq_flags = 4'b0010; ext_rst_req = 1; pa_wake_en = '1; pa_in = '0;
    @(negedge clk); wdt_ovf = 0; ext_rst_req = 0;
    begin
      bit seen = 0;
      repeat (8) begin @(negedge clk); if (exit_valid || core_hold || !clk_en) seen = 1; end
      check(!seen, "R10 sources ignored while running", seen, 0);
    end
    restore();

    // R6 directed: flag pending at entry stays masked
    irq_flags = 4'b0001; irq_en = '1;
    enter_halt();
    quiet(30, "R6 pending flag masked");
    // new flag wakes, R7 vector with stack free
    @(negedge clk); irq_flags = 4'b0011; stack_full = 0;
    wait_exit(5, n, code);
    check(code == 1, "R7 vector code", code, 1);
    check(n == SETTLE_CYC + 1, "R3 settle length", n, SETTLE_CYC + 1);
    restore();

    // R7 directed: stack full -> resume
    irq_en = '1; stack_full = 1;
    enter_halt();
    @(negedge clk); irq_flags = 4'b0100;
    wait_exit(5, n, code);
    check(code == 0, "R7 stack full resumes", code, 0);
    stack_full = 0;
    restore();

    // R9 directed priority, with R10/R11 disturbance during settle
    enter_halt();
    @(negedge clk); ext_rst_req = 1; wdt_ovf = 1; irq_flags = 4'b1000;
    n = 0; code = -1;
    while (n < SETTLE_CYC + 20) begin
      @(negedge clk); n++;
      ext_rst_req = 0; wdt_ovf = 0; halt_req = 0;
      if (n == 10) begin halt_req = 1; wdt_ovf = 1; end
      if (exit_valid) begin code = exit_code; break; end
    end
    check(code == 3, "R9 external reset priority", code, 3);
    check(n == SETTLE_CYC + 1, "R11 halt_req in settle ignored", n, SETTLE_CYC + 1);
    @(negedge clk);
    check(core_hold == 0 && clk_en == 1, "R11 no re-entry", core_hold, 0);
    restore();

    // Random trials
    for (int t = 0; t < 40; t++) begin
      pa_wake_en = PA_W'($urandom);
      if (pa_wake_en == 0) pa_wake_en = 1;
      if (pa_wake_en == '1) pa_wake_en[0] = 0;
      irq_en = N_IRQ'($urandom);
      stack_full = $urandom_range(0, 1);
      pre = N_IRQ'($urandom);
      if (pre == '1) pre[N_IRQ-1] = 0;
      irq_flags = pre;
      enter_halt();
      // noise: falling edge on a disabled pin
      b = 0;
      while (pa_wake_en[b]) b++;
      @(negedge clk); pa_in[b] = 0;
      quiet($urandom_range(5, 12), "R5 disabled pin no wake");
      kind = $urandom_range(0, 4);
      newb = '0;
      @(negedge clk);
      case (kind)
        0: begin ext_rst_req = 1; expn = SETTLE_CYC + 1; end
        1: begin wdt_ovf = 1; expn = SETTLE_CYC + 1; end
        2, 4: begin
          b = $urandom_range(0, N_IRQ - 1);
          while (pre[b]) b = (b + 1) % N_IRQ;
          newb[b] = 1; irq_flags = pre | newb;
          if (kind == 4) wdt_ovf = 1;
          expn = SETTLE_CYC + 1;
        end
        default: begin
          b = $urandom_range(0, PA_W - 1);
          while (!pa_wake_en[b]) b = (b + 1) % PA_W;
          pa_in[b] = 0;
          expn = SETTLE_CYC + 3;
        end
      endcase
      expc = exp_code(kind == 0, kind == 1 || kind == 4, newb, irq_en, stack_full);
      wait_exit(6, n, code);
      case (kind)
        0: check(code == expc, "R9 full reset code", code, expc);
        1: check(code == expc, "R8 warm reset code", code, expc);
        2: check(code == expc, "R7 interrupt code", code, expc);
        4: check(code == expc, "R8 watchdog over interrupt", code, expc);
        default: check(code == expc, "R5 port wake resumes", code, expc);
      endcase
      check(n == expn, "R3 strobe timing", n, expn);
      restore();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule